// File: doc/BRIEF.md
# Hex Text Command Decoder

This block sits behind a serial byte receiver and turns short lines of ASCII text into transactions on a narrow register bus. Each incoming byte arrives with a one-cycle strobe. A line opens with a preamble letter and carries hexadecimal digits. A carriage return closes it. A line of four digits is a read request. A line of eight digits is a write request: the first four digits are the address and the last four are the data.

A bad line leaves the bus untouched and parks the decoder in a visible error state. Bad lines include a wrong digit count and a character that is not a hex digit. The decoder waits there until the next preamble, so the host can resend at once without a reset. The bus outputs are registered. A single-cycle strobe marks each new transaction.

Top module: `hexcmd_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released, the decoder is idle, `bus_valid_o` is 0 and `parse_err_o` is 0. Reset in the middle of a line discards that line, so digits and a CR sent afterwards without a preamble produce nothing.
- R2: The preamble `M` (0x4D), then exactly four hex digits, then CR (0x0D), produces a read. `bus_addr_o` equals the digits, `bus_write_o` is 0, and `bus_valid_o` pulses once.
- R3: A preamble, then exactly eight hex digits, then CR, produces a write. `bus_addr_o` is the first four digits, `bus_wdata_o` is the last four, and `bus_write_o` is 1. Within each field the first digit received is the most significant nibble.
- R4: Digits `0`-`9` decode to 0-9. Both `A`-`F` and `a`-`f` decode to 10-15.
- R5: `bus_valid_o` is high for exactly one cycle: the cycle after the edge that accepts the CR. `bus_addr_o`, `bus_wdata_o` and `bus_write_o` hold their values until the next transaction.
- R6: A CR after 0, 3 or any count other than 4 or 8 digits raises `parse_err_o`, and no valid pulse appears. A ninth digit also raises `parse_err_o` and produces no valid pulse.
- R7: A character that is not a hex digit, arriving between the preamble and the CR, raises `parse_err_o`. `G` is one such character. No transaction is issued.
- R8: When idle, bytes other than the preamble are ignored, with no error and no transaction. This covers a line feed (0x0A) after the CR and stray letters.
- R9: From the error state, a preamble clears `parse_err_o` and starts a new line. A good line sent right after a bad one is decoded correctly.
- R10: Bytes presented while `rx_valid_i` is low have no effect on the line being decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Strobe marking `rx_byte_i` valid for one cycle |
| bus_addr_o | output | 16 | Transaction address |
| bus_wdata_o | output | 16 | Write data |
| bus_write_o | output | 1 | 1 for write, 0 for read |
| bus_valid_o | output | 1 | One-cycle transaction strobe |
| parse_err_o | output | 1 | High while the decoder sits in the error state |

## Verification
The bench builds the decoder with its default 16-bit address and data widths and the default preamble and terminator bytes. Four-digit and eight-digit lines therefore reach the field split exactly as the bus uses it. With these widths, the all-ones and all-zero values reach the nibble packing, and so do the nine-digit overflow case and the zero-digit case. A table of lines runs good and bad commands back to back, so recovery from the error state follows every bad line. Directed cases cover reset in the middle of a line, gaps in the strobe, and the exact cycle of the valid pulse.

// File: rtl/hexcmd_pkg.sv
package hexcmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DIGITS = 2'd1,
    ST_ERROR  = 2'd2
  } parse_st_e;
endpackage

// File: rtl/hexcmd_nibble.sv
module hexcmd_nibble (
  input  logic [7:0] char_i,
  output logic [3:0] nib_o,
  output logic       is_hex_o
);
  logic is_num, is_up, is_lo;

  always_comb begin
    is_num   = (char_i >= 8'h30) && (char_i <= 8'h39);
    is_up    = (char_i >= 8'h41) && (char_i <= 8'h46);
    is_lo    = (char_i >= 8'h61) && (char_i <= 8'h66);
    is_hex_o = is_num || is_up || is_lo;
    // letters carry 1..6 in the low nibble; adding 9 gives 10..15
    nib_o    = char_i[3:0] + ((is_up || is_lo) ? 4'd9 : 4'd0);
  end

  // R4
  nibble_range_chk: assert final (!(is_num && nib_o > 4'd9));
endmodule

// File: rtl/hexcmd_shifter.sv
module hexcmd_shifter #(
  parameter int DIGITS = 8,
  localparam int ACC_W = DIGITS * 4,
  localparam int CNT_W = $clog2(DIGITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [3:0]       nib_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [ACC_W-1:0] acc_d;
  logic [CNT_W-1:0] cnt_d;
  logic             acc_en;

  always_comb begin
    acc_en = clr_i || push_i;
    acc_d  = acc_o;
    cnt_d  = cnt_o;
    if (clr_i) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (push_i) begin
      acc_d = {acc_o[ACC_W-5:0], nib_i};
      cnt_d = cnt_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o <= '0;
      cnt_o <= '0;
    end else if (acc_en) begin
      acc_o <= acc_d;
      cnt_o <= cnt_d;
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= CNT_W'(DIGITS));
endmodule

// File: rtl/hexcmd_decoder.sv
module hexcmd_decoder
  import hexcmd_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         DATA_W   = 16,
  parameter logic [7:0] PREAMBLE = 8'h4D,
  parameter logic [7:0] TERM     = 8'h0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rx_byte_i,
  input  logic              rx_valid_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_write_o,
  output logic              bus_valid_o,
  output logic              parse_err_o
);
  localparam int ADDR_DIG = ADDR_W / 4;
  localparam int DATA_DIG = DATA_W / 4;
  localparam int TOT_DIG  = ADDR_DIG + DATA_DIG;
  localparam int ACC_W    = TOT_DIG * 4;
  localparam int CNT_W    = $clog2(TOT_DIG + 1);

  parse_st_e        st_q, st_d;
  logic [3:0]       nib;
  logic             is_hex;
  logic             clr, push, issue_rd, issue_wr;
  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;

  hexcmd_nibble u_nib (
    .char_i  (rx_byte_i),
    .nib_o   (nib),
    .is_hex_o(is_hex)
  );

  hexcmd_shifter #(.DIGITS(TOT_DIG)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr),
    .push_i(push),
    .nib_i (nib),
    .acc_o (acc),
    .cnt_o (cnt)
  );

  always_comb begin
    st_d     = st_q;
    clr      = 1'b0;
    push     = 1'b0;
    issue_rd = 1'b0;
    issue_wr = 1'b0;
    if (rx_valid_i) begin
      unique case (st_q)
        ST_IDLE, ST_ERROR: begin
          if (rx_byte_i == PREAMBLE) begin
            st_d = ST_DIGITS;
            clr  = 1'b1;
          end
        end
        ST_DIGITS: begin
          if (is_hex) begin
            if (cnt == CNT_W'(TOT_DIG)) st_d = ST_ERROR;
            else                        push = 1'b1;
          end else if (rx_byte_i == TERM) begin
            issue_rd = (cnt == CNT_W'(ADDR_DIG));
            issue_wr = (cnt == CNT_W'(TOT_DIG));
            st_d     = (issue_rd || issue_wr) ? ST_IDLE : ST_ERROR;
          end else begin
            st_d = ST_ERROR;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_valid_o <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      bus_write_o <= 1'b0;
    end else begin
      bus_valid_o <= issue_rd || issue_wr;
      if (issue_rd) begin
        bus_addr_o  <= acc[ADDR_W-1:0];
        bus_write_o <= 1'b0;
      end
      if (issue_wr) begin
        bus_addr_o  <= acc[ACC_W-1 -: ADDR_W];
        bus_wdata_o <= acc[DATA_W-1:0];
        bus_write_o <= 1'b1;
      end
    end
  end

  assign parse_err_o = (st_q == ST_ERROR);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o |=> !bus_valid_o);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid_o |-> ($stable(bus_addr_o) && $stable(bus_write_o)));

  // R6
  no_valid_in_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parse_err_o |-> !bus_valid_o);

  // R10
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_i |=> $stable(st_q));

  // R9
  err_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (parse_err_o && rx_valid_i && rx_byte_i == PREAMBLE) |=> !parse_err_o);
endmodule

// File: tb/hexcmd_decoder_test.sv
`timescale 1ns/100ps
module hexcmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rx_byte;
  logic        rx_valid;
  logic [15:0] addr, wdata;
  logic        wr, vld, err;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  hexcmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .rx_byte_i(rx_byte), .rx_valid_i(rx_valid),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_write_o(wr),
    .bus_valid_o(vld), .parse_err_o(err)
  );

  always @(negedge clk) if (vld) pulses++;

  typedef struct packed {
    logic [95:0] msg;
    logic [7:0]  len;
    logic        exp_v;
    logic        exp_w;
    logic [15:0] exp_a;
    logic [15:0] exp_d;
    logic        exp_e;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{96'({"M1234", 8'h0D}),                    8'd6,  1'b1, 1'b0, 16'h1234, 16'h0000, 1'b0},
    '{96'({"MF00DBEEF", 8'h0D, 8'h0A}),         8'd11, 1'b1, 1'b1, 16'hF00D, 16'hBEEF, 1'b0},
    '{96'({"Mabcd", 8'h0D}),                    8'd6,  1'b1, 1'b0, 16'hABCD, 16'h0000, 1'b0},
    '{96'({"MABC", 8'h0D, 8'h0A}),              8'd6,  1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1},
    '{96'({"M", 8'h0D}),                        8'd2,  1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1},
    '{96'({"MABCG", 8'h0D}),                    8'd6,  1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1},
    '{96'({"M0000", 8'h0D}),                    8'd6,  1'b1, 1'b0, 16'h0000, 16'h0000, 1'b0},
    '{96'({"M123456789", 8'h0D}),               8'd11, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1},
    '{96'({"MFfFf0001", 8'h0D}),                8'd10, 1'b1, 1'b1, 16'hFFFF, 16'h0001, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte  = 8'h00;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    rx_valid = 1'b0;
    rx_byte  = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(vld == 1'b0 && err == 1'b0, "R1", "reset outputs", {vld, err}, 0);
    rst_n = 1'b1;
    settle();
    check(vld == 1'b0 && err == 1'b0, "R1", "after release", {vld, err}, 0);

    // table walk: R2 R3 R4 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      pulses = 0;
      for (int j = int'(VEC[i].len) - 1; j >= 0; j--) send(VEC[i].msg[j*8 +: 8]);
      settle();
      check(pulses == int'(VEC[i].exp_v), VEC[i].exp_e ? "R6/R7" : "R2/R3",
            $sformatf("vec%0d pulses", i), pulses, VEC[i].exp_v);
      check(err == VEC[i].exp_e, "R9", $sformatf("vec%0d err flag", i), err, VEC[i].exp_e);
      if (VEC[i].exp_v) begin
        check(addr == VEC[i].exp_a, "R4", $sformatf("vec%0d addr", i), addr, VEC[i].exp_a);
        check(wr == VEC[i].exp_w, "R3", $sformatf("vec%0d rw", i), wr, VEC[i].exp_w);
        if (VEC[i].exp_w)
          check(wdata == VEC[i].exp_d, "R3", $sformatf("vec%0d wdata", i), wdata, VEC[i].exp_d);
      end
    end

    // R8: stray bytes while idle
    pulses = 0;
    send(8'h0A); send("Z"); send("5"); send(8'h0D);
    settle();
    check(err == 1'b0 && pulses == 0, "R8", "idle stray bytes", {err, 8'(pulses)}, 0);

    // R5: exact pulse cycle and hold
    pulses = 0;
    send("M"); send("A"); send("B"); send("C"); send("D");
    @(negedge clk);
    rx_byte = 8'h0D; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_byte = 8'h00;
    check(vld == 1'b1, "R5", "valid cycle after CR", vld, 1);
    @(negedge clk);
    check(vld == 1'b0, "R5", "valid one cycle", vld, 0);
    repeat (5) @(negedge clk);
    check(addr == 16'hABCD && wr == 1'b0, "R5", "outputs held", {wr, addr}, 32'h0ABCD);
    check(pulses == 1, "R5", "pulse count", pulses, 1);

    // R10: strobe low bytes ignored mid-line
    pulses = 0;
    send("M"); send("1"); send("2");
    @(negedge clk); rx_byte = "Z";
    @(negedge clk); rx_byte = "9";
    @(negedge clk); rx_byte = 8'h0D;
    @(negedge clk); rx_byte = 8'h00;
    check(err == 1'b0, "R10", "no error from unstrobed", err, 0);
    send("3"); send("4"); send(8'h0D);
    settle();
    check(pulses == 1 && addr == 16'h1234, "R10", "line intact", addr, 16'h1234);

    // R1: reset in the middle of a line
    pulses = 0;
    send("M"); send("5"); send("6");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(vld == 1'b0 && err == 1'b0, "R1", "mid-line reset", {vld, err}, 0);
    rst_n = 1'b1;
    send("7"); send("8"); send(8'h0D);
    settle();
    check(pulses == 0 && err == 1'b0, "R1", "discarded line", {err, 8'(pulses)}, 0);

    finish_run();
  end
endmodule